// File: doc/BRIEF.md
# Registered ALU with Scaling Shifter

This block is an 8-bit arithmetic and logic datapath with a result scaler. On each rising clock edge it captures two operands, a 3-bit operation code and a 3-bit shift amount. The captured operands pass through an arithmetic/logic unit. The unit's result then passes through a left shifter that moves it 0 to 3 positions in one combinational step. The block therefore returns the ALU result multiplied by 1, 2, 4 or 8.

The outputs are combinational functions of the captured state. A result appears one clock edge after its inputs are presented. The shifter acts on every result, with no bypass path around it. The carry output reports the carry of the ALU stage and ignores the shift.

Top module: `aludp_top`

## Requirements
- R1: Operands, operation code and shift amount are captured on the rising clock edge. `res_o` and `cout_o` change only after that edge and reflect only the captured values.
- R2: While `rst_n` is low, all captured state is asynchronously zero. This selects code 000 on zero operands, so `res_o` reads 0 and `cout_o` reads 1.
- R3: Arithmetic codes work as follows. 3'b011 gives A+B. 3'b111 gives A-B, computed as A+~B+1. 3'b000 gives B-A, computed as ~A+B+1. `cout_o` is bit 8 of that 9-bit sum, so for a subtraction it is 1 when no borrow occurs.
- R4: Logic codes work as follows. 3'b001 gives A|B, 3'b010 gives A&B and 3'b100 gives A^B. `cout_o` is 0 for all of them.
- R5: Move codes work as follows. 3'b110 passes A and 3'b101 passes B, with `cout_o` at 0.
- R6: The ALU result is shifted left by `shift_i` positions (0 to 3) before it reaches `res_o`. Zeros enter at bit 0 and bits leaving bit 7 are lost.
- R7: Shift amounts 4 to 7 act exactly as a shift of 3.
- R8: `cout_o` does not depend on the shift amount.
- R9: With A=10, B=3, code 011 and a shift of 2, `res_o` is 52 (8'b00110100) and `cout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| op_i | input | 3 | ALU operation code |
| shift_i | input | 3 | Left shift amount, saturating at 3 |
| res_o | output | 8 | Shifted ALU result |
| cout_o | output | 1 | ALU carry before shifting |

## Verification
A fault in the captured registers shows at the ports immediately after the capturing edge. From that edge on, every result is built from a stale or corrupted operand, code or shift value. A fault in the carry chain appears only on arithmetic codes whose operands produce long carry runs, so the directed cases include sums and differences that ripple through every bit. A fault in the shift saturation shows only for shift codes 4 to 7, so all of those codes are compared against a shift of 3.

// File: rtl/aludp_pkg.sv
package aludp_pkg;
  typedef enum logic [2:0] {
    OP_BSUBA = 3'b000,
    OP_OR    = 3'b001,
    OP_AND   = 3'b010,
    OP_ADD   = 3'b011,
    OP_XOR   = 3'b100,
    OP_PASSB = 3'b101,
    OP_PASSA = 3'b110,
    OP_ASUBB = 3'b111
  } alu_op_e;

  function automatic logic op_is_arith(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_ASUBB) || (op == OP_BSUBA);
  endfunction
endpackage

// File: rtl/aludp_in_reg.sv
module aludp_in_reg #(
  parameter int W   = 8,
  parameter int SHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a_d,
  input  logic [W-1:0]   b_d,
  input  logic [2:0]     op_d,
  input  logic [SHW-1:0] sh_d,
  output logic [W-1:0]   a_q,
  output logic [W-1:0]   b_q,
  output logic [2:0]     op_q,
  output logic [SHW-1:0] sh_q
);
  // the datapath samples every cycle; enable kept explicit
  localparam logic CAP_EN = 1'b1;

  logic [W-1:0]   a_n, b_n;
  logic [2:0]     op_n;
  logic [SHW-1:0] sh_n;

  always_comb begin
    a_n  = a_q;
    b_n  = b_q;
    op_n = op_q;
    sh_n = sh_q;
    if (CAP_EN) begin
      a_n  = a_d;
      b_n  = b_d;
      op_n = op_d;
      sh_n = sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= '0;
      sh_q <= '0;
    end else begin
      a_q  <= a_n;
      b_q  <= b_n;
      op_q <= op_n;
      sh_q <= sh_n;
    end
  end
endmodule

// File: rtl/aludp_alu.sv
module aludp_alu
  import aludp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] y,
  output logic         cout
);
  logic [W-1:0] x_in, y_in;
  logic         c_in;
  logic [W-1:0] prop, gen, sum;
  logic [W:0]   chain;

  // operand conditioning for the shared adder
  always_comb begin
    x_in = a;
    y_in = b;
    c_in = 1'b0;
    unique case (op)
      OP_ASUBB: begin y_in = ~b; c_in = 1'b1; end
      OP_BSUBA: begin x_in = ~a; c_in = 1'b1; end
      default:  ;
    endcase
  end

  assign chain[0] = c_in;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign prop[i]    = x_in[i] ^ y_in[i];
      assign gen[i]     = x_in[i] & y_in[i];
      assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
      assign sum[i]     = prop[i] ^ chain[i];
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_OR:    y = a | b;
      OP_AND:   y = a & b;
      OP_XOR:   y = a ^ b;
      OP_PASSA: y = a;
      OP_PASSB: y = b;
      default:  y = sum;
    endcase
    cout = op_is_arith(op) ? chain[W] : 1'b0;
  end
endmodule

// File: rtl/aludp_shifter.sv
module aludp_shifter #(
  parameter int W     = 8,
  parameter int SHW   = 3,
  parameter int MAXSH = 3
) (
  input  logic [W-1:0]   d,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   q
);
  localparam int SLOG = (MAXSH < 2) ? 1 : $clog2(MAXSH + 1);
  localparam logic [SLOG-1:0] MAX_AMT = SLOG'(MAXSH);

  logic [SLOG-1:0] amt_sat;
  logic [W-1:0]    stage [SLOG+1];

  always_comb begin
    if (int'(amt) > MAXSH) amt_sat = MAX_AMT;
    else                   amt_sat = SLOG'(amt);
  end

  assign stage[0] = d;

  genvar k;
  generate
    for (k = 0; k < SLOG; k++) begin : g_stage
      assign stage[k+1] = amt_sat[k] ? (stage[k] << (1 << k)) : stage[k];
    end
  endgenerate

  assign q = stage[SLOG];
endmodule

// File: rtl/aludp_top.sv
module aludp_top #(
  parameter int W     = 8,
  parameter int SHW   = 3,
  parameter int MAXSH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [2:0]     op_i,
  input  logic [SHW-1:0] shift_i,
  output logic [W-1:0]   res_o,
  output logic           cout_o
);
  logic [W-1:0]   a_q, b_q, alu_y;
  logic [2:0]     op_q;
  logic [SHW-1:0] sh_q;

  aludp_in_reg #(.W(W), .SHW(SHW)) u_in (
    .clk(clk), .rst_n(rst_n),
    .a_d(a_i), .b_d(b_i), .op_d(op_i), .sh_d(shift_i),
    .a_q(a_q), .b_q(b_q), .op_q(op_q), .sh_q(sh_q)
  );

  aludp_alu #(.W(W)) u_alu (
    .a(a_q), .b(b_q), .op(op_q), .y(alu_y), .cout(cout_o)
  );

  aludp_shifter #(.W(W), .SHW(SHW), .MAXSH(MAXSH)) u_shf (
    .d(alu_y), .amt(sh_q), .q(res_o)
  );
endmodule

// File: rtl/aludp_chk.sv
module aludp_chk #(
  parameter int W     = 8,
  parameter int SHW   = 3,
  parameter int MAXSH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   a_q,
  input logic [W-1:0]   b_q,
  input logic [2:0]     op_q,
  input logic [SHW-1:0] sh_q,
  input logic [W-1:0]   res_o,
  input logic           cout_o
);
  localparam logic [W-1:0] LOW_MASK = W'((1 << MAXSH) - 1);

  // R1: operand A register follows the port one edge later
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_q == $past(a_i)));

  // R4 / R5: non-arithmetic codes never raise carry
  p_logic_nocarry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q inside {3'b001, 3'b010, 3'b100, 3'b101, 3'b110}) |-> !cout_o);

  // R5: pass A with zero shift reproduces the captured operand
  p_pass_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 3'b110 && sh_q == '0) |-> (res_o == a_q));

  // R6 / R7: at the largest shift the low bits are zero-filled
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sh_q) >= MAXSH) |-> ((res_o & LOW_MASK) == '0));

  // R8: carry holds while only the shift amount may move
  p_carry_shift_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(a_q) && $stable(b_q) && $stable(op_q)) |-> $stable(cout_o));
endmodule

bind aludp_top aludp_chk #(.W(W), .SHW(SHW), .MAXSH(MAXSH)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .a_q(a_q), .b_q(b_q),
  .op_q(op_q), .sh_q(sh_q), .res_o(res_o), .cout_o(cout_o)
);

// File: tb/aludp_top_tb.sv
`timescale 1ns/1ps
module aludp_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] a_i, b_i;
  logic [2:0] op_i, shift_i;
  logic [7:0] res_o;
  logic       cout_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aludp_top u_dut (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i),
    .op_i(op_i), .shift_i(shift_i), .res_o(res_o), .cout_o(cout_o)
  );

  function automatic logic [8:0] model(input int a, input int b,
                                       input int op, input int sh);
    int r, c, s;
    c = 0;
    case (op)
      3: begin r = a + b;               c = (r >> 8) & 1; end
      7: begin r = a + (255 - b) + 1;   c = (r >> 8) & 1; end
      0: begin r = (255 - a) + b + 1;   c = (r >> 8) & 1; end
      1: r = a | b;
      2: r = a & b;
      4: r = a ^ b;
      5: r = b;
      default: r = a;
    endcase
    s = (sh > 3) ? 3 : sh;
    r = ((r & 255) * (1 << s)) & 255;
    return {c[0], r[7:0]};
  endfunction

  task automatic check(input string req, input logic [7:0] er, input logic ec);
    total++;
    if (res_o !== er || cout_o !== ec) begin
      bad++;
      $display("FAIL %s: res=%0d cout=%0b expected res=%0d cout=%0b",
               req, res_o, cout_o, er, ec);
    end
  endtask

  task automatic step(input int a, input int b, input int op, input int sh,
                      input string req);
    logic [8:0] e;
    @(negedge clk);
    a_i = 8'(a); b_i = 8'(b); op_i = 3'(op); shift_i = 3'(sh);
    @(posedge clk); #1;
    e = model(a, b, op, sh);
    check(req, e[7:0], e[8]);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    a_i = 8'hFF; b_i = 8'h0F; op_i = 3'b011; shift_i = 3'd2;
    repeat (2) @(posedge clk); #1;
    check("R2 reset", 8'd0, 1'b1);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_latency;
    step(20, 1, 3, 0, "R1 first");
    @(negedge clk);
    a_i = 8'd7; b_i = 8'd8; op_i = 3'b011; shift_i = 3'd1;
    #1; check("R1 hold before edge", 8'd21, 1'b0);
    @(posedge clk); #1; check("R1 after edge", 8'd30, 1'b0);
  endtask

  task automatic t_example;
    step(10, 3, 3, 2, "R9 example");
    check("R9 literal", 8'b00110100, 1'b0);
  endtask

  task automatic t_arith;
    step(200, 100, 3, 0, "R3 add carry");
    step(255, 1, 3, 0, "R3 add ripple");
    step(5, 9, 7, 0, "R3 a-b borrow");
    step(9, 5, 7, 0, "R3 a-b");
    step(5, 9, 0, 0, "R3 b-a");
    step(9, 5, 0, 1, "R3 b-a borrow shifted");
    step(0, 0, 7, 0, "R3 a-b zero");
  endtask

  task automatic t_logic;
    step(8'hA5, 8'h3C, 1, 0, "R4 or");
    step(8'h89, 8'h81, 2, 0, "R4 and");
    step(8'hF0, 8'hFF, 4, 1, "R4 xor");
    step(8'h01, 8'hEE, 6, 0, "R5 pass a");
    step(8'h11, 8'hC3, 5, 0, "R5 pass b");
  endtask

  task automatic t_shift;
    for (int s = 0; s < 4; s++) step(8'h4B, 0, 6, s, "R6 shift");
    step(8'hFF, 0, 6, 3, "R6 discard");
    for (int s = 4; s < 8; s++) step(8'hC7, 0, 6, s, "R7 saturate");
  endtask

  task automatic t_carry_shift;
    for (int s = 0; s < 8; s++) step(180, 180, 3, s, "R8 carry vs shift");
  endtask

  task automatic t_async_reset;
    step(50, 60, 3, 1, "R2 pre");
    @(negedge clk); #1;
    rst_n = 1'b0; #0.5;
    check("R2 async", 8'd0, 1'b1);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: res=%0d cout=%0b expected completion", res_o, cout_o);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_example();
    t_arith();
    t_logic();
    t_shift();
    t_carry_shift();
    t_async_reset();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule